// File: doc/BRIEF.md
# E1 Signaling Multiframe Aligner

This block finds the 16-frame channel-associated-signaling multiframe in an E1 receive stream once basic frame alignment is held. Each aligned frame delivers a single-cycle strobe together with that frame's timeslot 16 byte. While basic alignment is present, the block hunts for a byte whose upper four bits are all zero. It takes that frame as frame 0 of the multiframe at once, with no confirming frame.

When it is locked, the block numbers every incoming frame from 0 to 15. It checks the alignment nibble only in the frame it numbers 0. One bad frame 0 is tolerated. A second bad frame 0 in a row drops the lock and starts a new hunt. A loss of basic alignment drops the lock at once, whatever the multiframe state.

Top module: `cas_mf_aligner`

## Requirements
- R1: After reset, `mf_sync_n` is 1 and `mf_frame` is 0.
- R2: While `bas_lock_n` is 1, strobes have no effect: `mf_sync_n` stays 1 and `mf_frame` stays 0, even for an all-zero nibble.
- R3: While hunting with `bas_lock_n` at 0, the first strobe whose `ts16_byte[7:4]` is 0000 causes `mf_sync_n` to read 0 and `mf_frame` to read 0 in the cycle after that strobe. Bits 3:0 do not matter.
- R4: While hunting, a strobe whose `ts16_byte[7:4]` is not 0000 leaves the block unlocked with `mf_frame` at 0.
- R5: While locked, each strobe advances `mf_frame` by one, wrapping from 15 to 0, in the cycle after the strobe. Between strobes, both outputs hold their values.
- R6: While locked, the nibble is ignored in every frame other than the one numbered 0. A nonzero nibble, or a zero nibble, in frames 1 to 15 neither breaks the lock nor moves the numbering.
- R7: While locked, a single frame 0 with a nonzero nibble keeps the lock. A frame 0 with 0000 clears the record of errored multiframes.
- R8: The second consecutive frame 0 with a nonzero nibble sets `mf_sync_n` to 1 and `mf_frame` to 0 in the cycle after that strobe.
- R9: When `bas_lock_n` goes to 1 while the block is locked, `mf_sync_n` reads 1 and `mf_frame` reads 0 from the next cycle. Locking again needs a new all-zero nibble after basic alignment returns.
- R10: While unlocked, `mf_frame` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per aligned frame |
| ts16_byte | input | 8 | Timeslot 16 byte of the strobed frame |
| bas_lock_n | input | 1 | Basic frame alignment status, 0 = aligned |
| mf_sync_n | output | 1 | Multiframe sync status, 0 = aligned |
| mf_frame | output | 4 | Frame number within the signaling multiframe |

## Verification
The bench builds the block with its defaults: a 16-frame multiframe, a loss limit of two errored multiframes and an 8-bit timeslot byte. With these values, whole multiframes are short enough to run back to back. This brings every wrap from 15 to 0 within reach, as well as both the single-error recovery and the two-error loss. Zero and nonzero nibbles are placed in the middle frames to show they are ignored. Basic alignment is dropped both during the hunt and during lock.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;
  typedef enum logic {
    MF_HUNT   = 1'b0,
    MF_LOCKED = 1'b1
  } mf_state_e;
endpackage

// File: rtl/mfas_match.sv
// Compares the top PAT_W bits of a timeslot byte with the alignment pattern.
module mfas_match #(
  parameter int              BYTE_W  = 8,
  parameter int              PAT_W   = 4,
  parameter logic [PAT_W-1:0] PATTERN = '0
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic              hit
);
  always_comb begin
    hit = (byte_in[BYTE_W-1 -: PAT_W] == PATTERN);
  end
endmodule

// File: rtl/mf_frame_ctr.sv
// Position within the multiframe; clear takes priority over advance.
module mf_frame_ctr #(
  parameter int MF_LEN = 16,
  localparam int FW    = $clog2(MF_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [FW-1:0] cnt,
  output logic          at_last
);
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (advance) begin
      if (cnt_q == FW'(MF_LEN - 1)) cnt_d = '0;
      else                          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear || advance)  cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == FW'(MF_LEN - 1));
endmodule

// File: rtl/mf_err_ctr.sv
// Counts consecutive errored multiframes.
module mf_err_ctr #(
  parameter int LIMIT = 2,
  localparam int EW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_last
);
  logic [EW-1:0] err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (clear)     err_d = '0;
    else if (bump) err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             err_q <= '0;
    else if (clear || bump) err_q <= err_d;
  end

  assign at_last = (err_q == EW'(LIMIT - 1));
endmodule

// File: rtl/cas_mf_aligner.sv
module cas_mf_aligner #(
  parameter int MF_LEN     = 16,
  parameter int LOSS_LIMIT = 2,
  parameter int BYTE_W     = 8,
  parameter int PAT_W      = 4,
  localparam int FW        = $clog2(MF_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] ts16_byte,
  input  logic              bas_lock_n,
  output logic              mf_sync_n,
  output logic [FW-1:0]     mf_frame
);
  import cas_mf_pkg::*;

  mf_state_e state_q, state_d;
  logic      pat_hit;
  logic      ctr_clear, ctr_adv, ctr_last;
  logic      err_clear, err_bump, err_last;
  logic [FW-1:0] ctr_val;

  mfas_match #(.BYTE_W(BYTE_W), .PAT_W(PAT_W), .PATTERN('0)) u_match (
    .byte_in (ts16_byte),
    .hit     (pat_hit)
  );

  mf_frame_ctr #(.MF_LEN(MF_LEN)) u_fctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctr_clear),
    .advance (ctr_adv),
    .cnt     (ctr_val),
    .at_last (ctr_last)
  );

  mf_err_ctr #(.LIMIT(LOSS_LIMIT)) u_ectr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (err_clear),
    .bump    (err_bump),
    .at_last (err_last)
  );

  always_comb begin
    state_d   = state_q;
    ctr_clear = 1'b0;
    ctr_adv   = 1'b0;
    err_clear = 1'b0;
    err_bump  = 1'b0;
    unique case (state_q)
      MF_HUNT: begin
        ctr_clear = 1'b1;
        err_clear = 1'b1;
        if (!bas_lock_n && frame_stb && pat_hit) state_d = MF_LOCKED;
      end
      MF_LOCKED: begin
        if (bas_lock_n) begin
          state_d   = MF_HUNT;
          ctr_clear = 1'b1;
          err_clear = 1'b1;
        end else if (frame_stb) begin
          ctr_adv = 1'b1;
          if (ctr_last) begin
            // this strobe is frame 0 of the next multiframe
            if (pat_hit) begin
              err_clear = 1'b1;
            end else if (err_last) begin
              state_d   = MF_HUNT;
              ctr_clear = 1'b1;
              err_clear = 1'b1;
            end else begin
              err_bump = 1'b1;
            end
          end
        end
      end
      default: state_d = MF_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MF_HUNT;
    else        state_q <= state_d;
  end

  assign mf_sync_n = (state_q != MF_LOCKED);
  assign mf_frame  = ctr_val;
endmodule

// File: rtl/cas_mf_aligner_chk.sv
module cas_mf_aligner_chk #(
  parameter int MF_LEN = 16,
  parameter int BYTE_W = 8,
  parameter int PAT_W  = 4,
  localparam int FW    = $clog2(MF_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic [BYTE_W-1:0] ts16_byte,
  input logic              bas_lock_n,
  input logic              mf_sync_n,
  input logic [FW-1:0]     mf_frame
);
  // R2, R9
  assert_bas_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bas_lock_n |=> mf_sync_n);

  // R3
  assert_first_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_sync_n && !bas_lock_n && frame_stb && ts16_byte[BYTE_W-1 -: PAT_W] == '0)
    |=> (!mf_sync_n && mf_frame == '0));

  // R4
  assert_hunt_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_sync_n && frame_stb && ts16_byte[BYTE_W-1 -: PAT_W] != '0) |=> mf_sync_n);

  // R5, R6
  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_sync_n && !bas_lock_n && frame_stb && mf_frame != FW'(MF_LEN - 1))
    |=> (!mf_sync_n && mf_frame == FW'($past(mf_frame) + 1'b1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !bas_lock_n) |=> ($stable(mf_sync_n) && $stable(mf_frame)));

  // R8: a loss needs a dropped basic lock or a bad frame 0
  assert_loss_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_sync_n) |-> ($past(bas_lock_n) ||
      ($past(frame_stb) && $past(mf_frame) == FW'(MF_LEN - 1) &&
       $past(ts16_byte[BYTE_W-1 -: PAT_W]) != '0)));

  // R10
  assert_idle_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mf_sync_n |-> (mf_frame == '0));
endmodule

bind cas_mf_aligner cas_mf_aligner_chk #(.MF_LEN(MF_LEN), .BYTE_W(BYTE_W), .PAT_W(PAT_W)) u_chk (.*);

// File: tb/sim_cas_mf_aligner.sv
module sim_cas_mf_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] ts16_byte = 8'h00;
  logic       bas_lock_n = 1'b1;
  logic       mf_sync_n;
  logic [3:0] mf_frame;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state, derived from the requirements
  bit       m_lock = 1'b0;
  int       m_frame = 0;
  int       m_err = 0;
  bit       m_bas_n = 1'b1;
  logic [4:0] last_exp = 5'b1_0000;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  cas_mf_aligner u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ts16_byte(ts16_byte),
    .bas_lock_n(bas_lock_n), .mf_sync_n(mf_sync_n), .mf_frame(mf_frame)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got sync_n=%0b frame=%0d, expected sync_n=%0b frame=%0d",
               tag, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  function automatic logic [4:0] model_out();
    return m_lock ? {1'b0, 4'(m_frame)} : 5'b1_0000;
  endfunction

  // driver: one strobe, expectation pushed into the scoreboard
  task automatic send(input logic [7:0] b, input string tag);
    @(negedge clk);
    frame_stb = 1'b1;
    ts16_byte = b;
    if (m_bas_n) begin
      m_lock = 1'b0; m_frame = 0; m_err = 0;
    end else if (!m_lock) begin
      if (b[7:4] == 4'h0) begin m_lock = 1'b1; m_frame = 0; m_err = 0; end
    end else begin
      m_frame = (m_frame + 1) % 16;
      if (m_frame == 0) begin
        if (b[7:4] != 4'h0) begin
          m_err++;
          if (m_err == 2) begin m_lock = 1'b0; m_frame = 0; m_err = 0; end
        end else m_err = 0;
      end
    end
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
    @(negedge clk);
    frame_stb = 1'b0;
    ts16_byte = 8'hA5;
  endtask

  task automatic set_bas(input bit v);
    @(negedge clk);
    bas_lock_n = v;
    m_bas_n    = v;
    if (v) begin m_lock = 1'b0; m_frame = 0; m_err = 0; end
    last_exp = model_out();
    @(negedge clk);
  endtask

  // 15 middle frames with the given upper-nibble pattern (R6)
  task automatic send_mid(input bit zero_nib);
    for (int f = 1; f < 16; f++)
      send(zero_nib ? {4'h0, 4'(f)} : {4'(f), 4'h3}, "R5/R6");
  endtask

  // monitor: pops the scoreboard after each strobe, checks holding otherwise
  initial begin
    forever begin
      logic s;
      @(posedge clk);
      s = frame_stb;
      #1;
      if (rst_n && !done) begin
        if (s) begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: result with no expectation, got %0b expected none", mf_sync_n);
          end else begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            check(t, {mf_sync_n, mf_frame}, e);
          end
        end else begin
          check("R5/R9 hold", {mf_sync_n, mf_frame}, last_exp);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {mf_sync_n, mf_frame}, 5'b1_0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {mf_sync_n, mf_frame}, 5'b1_0000);

    // R2: zero nibbles ignored without basic lock
    send(8'h00, "R2");
    send(8'h07, "R2");
    set_bas(1'b0);

    // R4: nonzero nibbles keep hunting
    send(8'h5A, "R4");
    send(8'h10, "R4");
    send(8'h80, "R4 R10");
    // R3: first zero nibble locks, low bits ignored
    send(8'h0F, "R3");
    send_mid(1'b0);
    send(8'h0B, "R5 wrap");
    send_mid(1'b1);
    send(8'h00, "R5 wrap");

    // R7: one errored multiframe tolerated, then cleared by a good one
    send_mid(1'b0);
    send(8'hF0, "R7 first error");
    send_mid(1'b0);
    send(8'h02, "R7 recovered");
    send_mid(1'b0);
    send(8'h40, "R7 single error");
    send_mid(1'b1);
    // R8: second consecutive errored multiframe drops lock
    send(8'h90, "R8 loss");
    send(8'h30, "R8 hunting");
    send(8'h00, "R3 relock");
    send(8'h11, "R6");
    send(8'h22, "R6");

    // R9: basic alignment lost while locked
    set_bas(1'b1);
    send(8'h00, "R9 R2");
    set_bas(1'b0);
    send(8'h30, "R9 no relock");
    send(8'h00, "R9 relock");
    send(8'h00, "R6 frame1");
    repeat (3) @(negedge clk);

    done = 1'b1;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d left, expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule